// File: doc/BRIEF.md
# DMA Channel Service Sequencer

This block sits behind the register file of a four-channel DMA controller and decides, cycle by cycle, which channel owns the transfer path. A channel competes for service only when the controller is enabled, its mask bit is clear, its request is raised and it has not already run out. When the requesting device acknowledges a unit, the sequencer advances the granted channel's count and address. It also issues a single-cycle memory read or write strobe that depends on the channel's transfer kind, and it flags terminal count on the last unit.

Programming inputs (mask, modes, base address and base count) are plain levels from a register block. A one-cycle reprogram pulse per channel rearms that channel. A transfer spans base count plus one units. A parameter sets the byte width of a unit, so a word controller presents byte addresses shifted left by one. After terminal count, a channel with automatic reload starts again from its base values. A channel without it stays idle until it is reprogrammed.

Top module: `dma_svc_seq`

## Requirements
- R1: While `ctl_disable` is high, `grant_valid` is low and neither memory strobe fires, whatever the requests.
- R2: A channel is eligible only when its `chan_mask` bit is 0, its `chan_req` bit is 1 and it is not stopped after a completed non-reload transfer.
- R3: Among eligible channels, the lowest index is granted (`grant_ch`).
- R4: Each cycle with `unit_ack` high and a valid grant advances the granted channel's current count (`cur_count`, CW+1 bits per channel) by one. An acknowledge with no grant changes no count and fires no strobe.
- R5: The unit acknowledged while the current count equals the base count is the last one. In that cycle `tc_pulse` is high, and from the next cycle the channel's `tc_status` bit is 1, for transfer modes demand (0), single (1) and block (2).
- R6: In cascade mode (3), the last unit raises neither `tc_pulse` nor `tc_status`, the count wraps to 0 and no memory strobe fires.
- R7: Transfer kind (2 bits per channel) decides the strobe on an acknowledged unit: 0 (verify) none, 1 (write) `mem_wr`, 2 (read) `mem_rd`, 3 none. The two strobes are never high together.
- R8: `mem_addr` is the granted channel's current address shifted left by `UNIT_SHIFT`. After each unit the address moves by one, downward when the channel's `addr_down` bit is 1 and upward otherwise.
- R9: After the last unit, a channel with `auto_reload` set returns to count 0 and its base address and stays eligible. Without it, the channel keeps count base+1 and is not granted until reprogrammed.
- R10: A block-mode (2) channel that has been acknowledged at least once keeps the grant until its last unit, even if its request drops or a lower-index request appears, while it stays unmasked and the controller stays enabled.
- R11: A `chan_prog` pulse sets that channel's count to 0, loads its current address from the base address, clears its stopped state and clears its `tc_status` bit.
- R12: After reset, all counts, addresses and `tc_status` bits are 0 and no channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_disable | input | 1 | Controller disable from the command register |
| chan_mask | input | NCH | Per-channel mask, 1 blocks service |
| chan_req | input | NCH | Per-channel request level |
| chan_prog | input | NCH | Per-channel reprogram pulse |
| xfer_mode | input | 2*NCH | Transfer mode per channel: 0 demand, 1 single, 2 block, 3 cascade |
| xfer_kind | input | 2*NCH | Transfer kind per channel: 0 verify, 1 write, 2 read, 3 reserved |
| addr_down | input | NCH | Per-channel address decrement select |
| auto_reload | input | NCH | Per-channel reload after terminal count |
| base_count | input | NCH*CW | Base count per channel (units minus one) |
| base_addr | input | NCH*AW | Base address per channel, in units |
| unit_ack | input | 1 | Device acknowledges one unit this cycle |
| grant_valid | output | 1 | A channel is being serviced |
| grant_ch | output | CHW | Index of the serviced channel |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | AW+UNIT_SHIFT | Byte address of the current unit |
| tc_pulse | output | 1 | High on the last unit of a counted transfer |
| tc_status | output | NCH | Sticky terminal-count flags |
| cur_count | output | NCH*(CW+1) | Units transferred so far, per channel |

## Verification
Arbitration is swept over every mask and request combination with the controller both enabled and disabled. This separates the mask, request and disable terms of eligibility from the index priority. Each channel then runs complete transfers for every transfer kind, both address directions and several short base counts. This separates the strobe decode, the address step direction, the last-unit detection and the stop after a non-reload transfer. Further runs cover automatic reload, cascade, a block-mode hold against a lower-index request, and an acknowledge with no grant. These show apart behaviour that plain single-mode transfers share.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;

  typedef enum logic [1:0] {
    XM_DEMAND  = 2'd0,
    XM_SINGLE  = 2'd1,
    XM_BLOCK   = 2'd2,
    XM_CASCADE = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    XK_VERIFY  = 2'd0,
    XK_WRITE   = 2'd1,
    XK_READ    = 2'd2,
    XK_RSVD    = 2'd3
  } xfer_kind_e;

endpackage

// File: rtl/svc_arbiter.sv
module svc_arbiter #(
  parameter int NCH = 4,
  parameter int CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctl_disable,
  input  logic [NCH-1:0] chan_mask,
  input  logic [NCH-1:0] chan_req,
  input  logic [NCH-1:0] chan_prog,
  input  logic [NCH-1:0] stopped,
  input  logic [NCH-1:0] is_block,
  input  logic           unit_done,
  input  logic           last_unit,
  output logic           grant_valid,
  output logic [CHW-1:0] grant_ch
);

  logic [NCH-1:0] eligible;
  logic           lock_valid;
  logic [CHW-1:0] lock_ch;
  logic           lock_live;

  function automatic logic [CHW-1:0] lowest_set(input logic [NCH-1:0] v);
    logic [CHW-1:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (v[i]) r = CHW'(i);
    end
    return r;
  endfunction

  assign eligible  = {NCH{!ctl_disable}} & ~chan_mask & chan_req & ~stopped;
  assign lock_live = lock_valid && !ctl_disable && !chan_mask[lock_ch] && !stopped[lock_ch];

  always_comb begin
    if (lock_live) begin
      grant_valid = 1'b1;
      grant_ch    = lock_ch;
    end else begin
      grant_valid = |eligible;
      grant_ch    = lowest_set(eligible);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_valid <= 1'b0;
      lock_ch    <= '0;
    end else begin
      if (lock_valid && !lock_live) lock_valid <= 1'b0;
      if (lock_valid && chan_prog[lock_ch]) lock_valid <= 1'b0;
      if (unit_done) begin
        if (last_unit) begin
          lock_valid <= 1'b0;
        end else if (is_block[grant_ch]) begin
          lock_valid <= 1'b1;
          lock_ch    <= grant_ch;
        end
      end
    end
  end

  AST_DISABLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_disable |-> !grant_valid); // R1
  AST_GRANT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !chan_mask[grant_ch]); // R2
  AST_GRANT_NOT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> !stopped[grant_ch]); // R9

endmodule

// File: rtl/svc_channel.sv
module svc_channel
  import dma_svc_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic [CW-1:0] base_cnt,
  input  logic [AW-1:0] base_addr,
  input  logic [1:0]    mode,
  input  logic          dec,
  input  logic          auto_ld,
  input  logic          unit_done,
  output logic [CW:0]   cur_cnt,
  output logic [AW-1:0] cur_addr,
  output logic          stopped,
  output logic          tc_flag,
  output logic          last_unit,
  output logic          tc_hit
);

  logic is_cascade;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic down);
    return down ? a - 1'b1 : a + 1'b1;
  endfunction

  function automatic logic is_last(input logic [CW:0] cnt, input logic [CW-1:0] base);
    return cnt == {1'b0, base};
  endfunction

  assign is_cascade = (mode == XM_CASCADE);
  assign last_unit  = is_last(cur_cnt, base_cnt);
  assign tc_hit     = last_unit && !is_cascade;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cnt  <= '0;
      cur_addr <= '0;
      stopped  <= 1'b0;
      tc_flag  <= 1'b0;
    end else if (prog) begin
      cur_cnt  <= '0;
      cur_addr <= base_addr;
      stopped  <= 1'b0;
      tc_flag  <= 1'b0;
    end else if (unit_done) begin
      if (!last_unit) begin
        cur_cnt  <= cur_cnt + 1'b1;
        cur_addr <= step_addr(cur_addr, dec);
      end else if (is_cascade) begin
        cur_cnt  <= '0;
        cur_addr <= base_addr;
      end else begin
        tc_flag <= 1'b1;
        if (auto_ld) begin
          cur_cnt  <= '0;
          cur_addr <= base_addr;
        end else begin
          cur_cnt  <= cur_cnt + 1'b1;
          cur_addr <= step_addr(cur_addr, dec);
          stopped  <= 1'b1;
        end
      end
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !prog && !last_unit) |=> (cur_cnt == $past(cur_cnt) + 1'b1)); // R4
  AST_TC_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !prog && tc_hit) |=> tc_flag); // R5
  AST_CASCADE_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !prog && is_cascade && !tc_flag) |=> !tc_flag); // R6
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !prog) |=> $stable(cur_cnt)); // R9
  AST_PROG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> (cur_cnt == '0 && !tc_flag && !stopped)); // R11

endmodule

// File: rtl/svc_strobe.sv
module svc_strobe
  import dma_svc_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CHW        = 2,
  parameter int AW         = 16,
  parameter int UNIT_SHIFT = 1,
  localparam int MAW       = AW + UNIT_SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grant_valid,
  input  logic [CHW-1:0]  grant_ch,
  input  logic            unit_ack,
  input  logic [2*NCH-1:0] xfer_mode,
  input  logic [2*NCH-1:0] xfer_kind,
  input  logic [NCH*AW-1:0] cur_addr_all,
  output logic            unit_done,
  output logic            mem_wr,
  output logic            mem_rd,
  output logic [MAW-1:0]  mem_addr
);

  logic [1:0]    sel_kind;
  logic [1:0]    sel_mode;
  logic [AW-1:0] sel_addr;

  function automatic logic [MAW-1:0] byte_addr(input logic [AW-1:0] a);
    logic [MAW-1:0] w;
    w = MAW'(a);
    return w << UNIT_SHIFT;
  endfunction

  assign sel_kind  = xfer_kind[2*grant_ch +: 2];
  assign sel_mode  = xfer_mode[2*grant_ch +: 2];
  assign sel_addr  = cur_addr_all[AW*grant_ch +: AW];
  assign unit_done = unit_ack && grant_valid;

  always_comb begin
    mem_wr = 1'b0;
    mem_rd = 1'b0;
    if (unit_done && sel_mode != XM_CASCADE) begin
      mem_wr = (sel_kind == XK_WRITE);
      mem_rd = (sel_kind == XK_READ);
    end
  end

  assign mem_addr = grant_valid ? byte_addr(sel_addr) : '0;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr && mem_rd)); // R7
  AST_STROBE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || mem_rd) |-> grant_valid); // R4

endmodule

// File: rtl/dma_svc_seq.sv
module dma_svc_seq
  import dma_svc_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CW         = 16,
  parameter int AW         = 16,
  parameter int UNIT_SHIFT = 1,
  localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int MAW       = AW + UNIT_SHIFT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_disable,
  input  logic [NCH-1:0]      chan_mask,
  input  logic [NCH-1:0]      chan_req,
  input  logic [NCH-1:0]      chan_prog,
  input  logic [2*NCH-1:0]    xfer_mode,
  input  logic [2*NCH-1:0]    xfer_kind,
  input  logic [NCH-1:0]      addr_down,
  input  logic [NCH-1:0]      auto_reload,
  input  logic [NCH*CW-1:0]   base_count,
  input  logic [NCH*AW-1:0]   base_addr,
  input  logic                unit_ack,
  output logic                grant_valid,
  output logic [CHW-1:0]      grant_ch,
  output logic                mem_wr,
  output logic                mem_rd,
  output logic [MAW-1:0]      mem_addr,
  output logic                tc_pulse,
  output logic [NCH-1:0]      tc_status,
  output logic [NCH*(CW+1)-1:0] cur_count
);

  logic [NCH-1:0]    stopped;
  logic [NCH-1:0]    is_block;
  logic [NCH-1:0]    last_vec;
  logic [NCH-1:0]    tc_hit_vec;
  logic [NCH*AW-1:0] cur_addr_all;
  logic              unit_done;
  logic              last_sel;

  assign last_sel = last_vec[grant_ch];
  assign tc_pulse = unit_done && tc_hit_vec[grant_ch] && (xfer_mode[2*grant_ch +: 2] != XM_CASCADE);

  svc_arbiter #(.NCH(NCH), .CHW(CHW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_disable (ctl_disable),
    .chan_mask   (chan_mask),
    .chan_req    (chan_req),
    .chan_prog   (chan_prog),
    .stopped     (stopped),
    .is_block    (is_block),
    .unit_done   (unit_done),
    .last_unit   (last_sel),
    .grant_valid (grant_valid),
    .grant_ch    (grant_ch)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic ch_done;
    assign ch_done     = unit_done && (grant_ch == CHW'(g));
    assign is_block[g] = (xfer_mode[2*g +: 2] == XM_BLOCK);

    svc_channel #(.CW(CW), .AW(AW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog      (chan_prog[g]),
      .base_cnt  (base_count[CW*g +: CW]),
      .base_addr (base_addr[AW*g +: AW]),
      .mode      (xfer_mode[2*g +: 2]),
      .dec       (addr_down[g]),
      .auto_ld   (auto_reload[g]),
      .unit_done (ch_done),
      .cur_cnt   (cur_count[(CW+1)*g +: CW+1]),
      .cur_addr  (cur_addr_all[AW*g +: AW]),
      .stopped   (stopped[g]),
      .tc_flag   (tc_status[g]),
      .last_unit (last_vec[g]),
      .tc_hit    (tc_hit_vec[g])
    );
  end

  svc_strobe #(.NCH(NCH), .CHW(CHW), .AW(AW), .UNIT_SHIFT(UNIT_SHIFT)) u_stb (
    .clk          (clk),
    .rst_n        (rst_n),
    .grant_valid  (grant_valid),
    .grant_ch     (grant_ch),
    .unit_ack     (unit_ack),
    .xfer_mode    (xfer_mode),
    .xfer_kind    (xfer_kind),
    .cur_addr_all (cur_addr_all),
    .unit_done    (unit_done),
    .mem_wr       (mem_wr),
    .mem_rd       (mem_rd),
    .mem_addr     (mem_addr)
  );

  AST_TC_ONLY_ON_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> (grant_valid && unit_ack)); // R5
  AST_BLOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && is_block[grant_ch] && !last_sel && !chan_prog[grant_ch])
    |=> (ctl_disable || chan_mask[$past(grant_ch)] || (grant_valid && grant_ch == $past(grant_ch)))); // R10

endmodule

// File: tb/tb_dma_svc_seq.sv
module tb_dma_svc_seq;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = 16;
  localparam int USH = 1;
  localparam int CHW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ctl_disable;
  logic [NCH-1:0] chan_mask, chan_req, chan_prog, addr_down, auto_reload;
  logic [2*NCH-1:0] xfer_mode, xfer_kind;
  logic [NCH*CW-1:0] base_count;
  logic [NCH*AW-1:0] base_addr;
  logic unit_ack;
  logic grant_valid;
  logic [CHW-1:0] grant_ch;
  logic mem_wr, mem_rd, tc_pulse;
  logic [AW+USH-1:0] mem_addr;
  logic [NCH-1:0] tc_status;
  logic [NCH*(CW+1)-1:0] cur_count;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dma_svc_seq #(.NCH(NCH), .CW(CW), .AW(AW), .UNIT_SHIFT(USH)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_disable(ctl_disable), .chan_mask(chan_mask),
    .chan_req(chan_req), .chan_prog(chan_prog), .xfer_mode(xfer_mode),
    .xfer_kind(xfer_kind), .addr_down(addr_down), .auto_reload(auto_reload),
    .base_count(base_count), .base_addr(base_addr), .unit_ack(unit_ack),
    .grant_valid(grant_valid), .grant_ch(grant_ch), .mem_wr(mem_wr), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .tc_pulse(tc_pulse), .tc_status(tc_status), .cur_count(cur_count)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [CW:0] cnt_of(input int ch);
    return cur_count[(CW+1)*ch +: CW+1];
  endfunction

  task automatic prog_ch(input int ch, input int base, input int addr);
    @(negedge clk);
    base_count[CW*ch +: CW] = CW'(base);
    base_addr[AW*ch +: AW]  = AW'(addr);
    chan_prog = NCH'(1) << ch;
    @(negedge clk);
    chan_prog = '0;
  endtask

  task automatic set_ch(input int ch, input int mode, input int kind, input bit dec, input bit ald);
    xfer_mode[2*ch +: 2] = 2'(mode);
    xfer_kind[2*ch +: 2] = 2'(kind);
    addr_down[ch]   = dec;
    auto_reload[ch] = ald;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ctl_disable = 1'b0; chan_mask = '1; chan_req = '0; chan_prog = '0;
    xfer_mode = '0; xfer_kind = '0; addr_down = '0; auto_reload = '0;
    base_count = '0; base_addr = '0; unit_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R12 reset state
    check("R12", "tc_status", 32'(tc_status), 0);
    check("R12", "cur_count", 32'(cur_count[31:0]), 0);
    check("R12", "cur_count_hi", 32'(cur_count[NCH*(CW+1)-1:32]), 0);
    check("R12", "mem_addr", 32'(mem_addr), 0);

    // R1 R2 R3 arbitration sweep
    for (int d = 0; d < 2; d++) begin
      for (int m = 0; m < 16; m++) begin
        for (int r = 0; r < 16; r++) begin
          logic [3:0] el;
          int lo;
          @(negedge clk);
          ctl_disable = d[0]; chan_mask = 4'(m); chan_req = 4'(r);
          #1;
          el = (d != 0) ? 4'b0 : (~4'(m) & 4'(r));
          lo = 0;
          for (int i = 3; i >= 0; i--) if (el[i]) lo = i;
          check((d != 0) ? "R1" : "R2", "grant_valid", 32'(grant_valid), 32'(el != 0));
          if (el != 0) check("R3", "grant_ch", 32'(grant_ch), 32'(lo));
        end
      end
    end
    ctl_disable = 1'b0;

    // R4 R5 R7 R8 R9 R11 full transfers
    for (int ch = 0; ch < NCH; ch++) begin
      for (int kind = 0; kind < 4; kind++) begin
        for (int dec = 0; dec < 2; dec++) begin
          for (int base = 0; base < 3; base++) begin
            int a0;
            a0 = 16'h0100 + ch * 16'h40 + kind * 8;
            @(negedge clk);
            chan_mask = ~(NCH'(1) << ch);
            chan_req  = NCH'(1) << ch;
            set_ch(ch, 1, kind, dec[0], 1'b0);
            prog_ch(ch, base, a0);
            for (int k = 0; k <= base; k++) begin
              logic [AW-1:0] ak;
              @(negedge clk);
              unit_ack = 1'b1;
              #1;
              ak = (dec != 0) ? AW'(a0 - k) : AW'(a0 + k);
              check("R8", "mem_addr", 32'(mem_addr), 32'({ak, 1'b0}));
              check("R7", "mem_wr", 32'(mem_wr), 32'(kind == 1));
              check("R7", "mem_rd", 32'(mem_rd), 32'(kind == 2));
              check("R5", "tc_pulse", 32'(tc_pulse), 32'(k == base));
            end
            @(negedge clk);
            unit_ack = 1'b0;
            #1;
            check("R4", "cur_count", 32'(cnt_of(ch)), 32'(base + 1));
            check("R5", "tc_status", 32'(tc_status[ch]), 1);
            check("R9", "stopped_grant", 32'(grant_valid), 0);
            prog_ch(ch, base, a0);
            #1;
            check("R11", "cur_count", 32'(cnt_of(ch)), 0);
            check("R11", "tc_status", 32'(tc_status[ch]), 0);
            check("R11", "grant_valid", 32'(grant_valid), 1);
          end
        end
      end
    end

    // R4 acknowledge with no grant
    @(negedge clk);
    chan_req = '0; chan_mask = '0; unit_ack = 1'b1;
    #1;
    check("R4", "no_grant_wr", 32'(mem_wr), 0);
    check("R4", "no_grant_rd", 32'(mem_rd), 0);
    @(negedge clk);
    unit_ack = 1'b0;
    #1;
    check("R4", "no_grant_count", 32'(cnt_of(0)), 0);

    // R9 automatic reload on channel 2
    @(negedge clk);
    chan_mask = 4'b1011; chan_req = 4'b0100;
    set_ch(2, 1, 1, 1'b0, 1'b1);
    prog_ch(2, 1, 16'h0200);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); unit_ack = 1'b1; #1;
      check("R5", "auto_tc_pulse", 32'(tc_pulse), 32'(k == 1));
    end
    @(negedge clk); unit_ack = 1'b0; #1;
    check("R9", "auto_count", 32'(cnt_of(2)), 0);
    check("R9", "auto_grant", 32'(grant_valid), 1);
    check("R9", "auto_addr", 32'(mem_addr), 32'h400);
    check("R5", "auto_tc_status", 32'(tc_status[2]), 1);

    // R6 cascade on channel 1
    @(negedge clk);
    chan_mask = 4'b1101; chan_req = 4'b0010;
    set_ch(1, 3, 1, 1'b0, 1'b0);
    prog_ch(1, 1, 16'h0300);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk); unit_ack = 1'b1; #1;
      check("R6", "cascade_wr", 32'(mem_wr), 0);
      check("R6", "cascade_tc_pulse", 32'(tc_pulse), 0);
    end
    @(negedge clk); unit_ack = 1'b0; #1;
    check("R6", "cascade_count", 32'(cnt_of(1)), 0);
    check("R6", "cascade_tc_status", 32'(tc_status[1]), 0);
    check("R6", "cascade_grant", 32'(grant_valid), 1);

    // R10 block hold on channel 3
    @(negedge clk);
    chan_mask = 4'b0000; chan_req = 4'b1000;
    set_ch(3, 2, 2, 1'b0, 1'b0);
    prog_ch(3, 2, 16'h0500);
    @(negedge clk); unit_ack = 1'b1; #1;
    check("R10", "block_first", 32'(grant_ch), 3);
    @(negedge clk); unit_ack = 1'b0; chan_req = 4'b0001; #1;
    check("R10", "block_hold_valid", 32'(grant_valid), 1);
    check("R10", "block_hold_ch", 32'(grant_ch), 3);
    for (int k = 1; k < 3; k++) begin
      @(negedge clk); unit_ack = 1'b1; #1;
      check("R10", "block_unit_ch", 32'(grant_ch), 3);
      check("R7", "block_rd", 32'(mem_rd), 1);
      check("R5", "block_tc_pulse", 32'(tc_pulse), 32'(k == 2));
    end
    @(negedge clk); unit_ack = 1'b0; #1;
    check("R10", "block_release", 32'(grant_ch), 0);
    check("R5", "block_tc_status", 32'(tc_status[3]), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule